// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Buffer

This block turns an asynchronous serial input into characters. An external baud divisor supplies a one-cycle enable at sixteen times the bit rate. The receiver waits for a falling edge on the line and confirms it at the middle of the start bit. It then samples each data bit, the optional parity bit and the first stop bit at the middle of its bit period. The character width, parity use and parity sense come from static format inputs. A second stop bit needs no handling, because the receiver treats it as idle line.

Each finished character is stored with three flags of its own: parity error, framing error and break. After reset the storage is a single holding register (character mode). Setting `fifo_mode` switches it to a first-in first-out queue of `DEPTH` entries. The consumer sees the character at the head together with its flags and a data-ready indication, and removes it with `rd_en`. Overrun is a separate sticky flag. It is raised when a character finishes and there is no room for it, and a status read clears it.

Top module: `srx_tagged`

## Requirements
- R1: After reset, `data_ready` and `overrun` are 0, and storage is in character mode with a capacity of one entry.
- R2: A falling edge starts reception only if the line is still low at the 8th enable tick after the edge. If the line is high at that tick, the edge is discarded and nothing is stored.
- R3: `data_bits` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Bits arrive least significant first, and the unused upper bits of `head_data` read 0. Each bit is sampled 16 ticks after the previous sample.
- R4: When `parity_en` is 1, one parity bit follows the data bits. `parity_even` = 1 expects an even count of ones over data and parity, and 0 expects an odd count. A mismatch sets `head_perr` for that entry only.
- R5: If the first stop bit is sampled low, the stored entry has `head_ferr` = 1.
- R6: A frame whose data, parity and stop positions are all low is stored once, with data 0, `head_brk` = 1 and `head_ferr` = 1. No further start is accepted until the line has been seen high.
- R7: In character mode, a second character that finishes while one is held is discarded. The held character stays at the head and `overrun` becomes 1.
- R8: In FIFO mode, up to `DEPTH` characters are held and read out in arrival order, each with its own flags.
- R9: A character that finishes while the FIFO is full is discarded and sets `overrun`. The stored entries are unchanged. `overrun` stays 1 until a `status_rd` pulse.
- R10: Any change of `fifo_mode` empties the storage, and `data_ready` falls on the following cycle.
- R11: `rd_en` while storage is empty has no effect: `data_ready` stays 0 and the next character is stored normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| data_bits | input | 2 | Character width code (0..3 gives 5..8 bits) |
| parity_en | input | 1 | A parity bit is present |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| fifo_mode | input | 1 | 0 selects the holding register, 1 selects the FIFO |
| rd_en | input | 1 | Removes the head entry |
| status_rd | input | 1 | Clears the overrun flag |
| data_ready | output | 1 | At least one entry is stored |
| head_data | output | 8 | Data of the head entry |
| head_perr | output | 1 | Parity error flag of the head entry |
| head_ferr | output | 1 | Framing error flag of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with `DEPTH` = 16 and two synchronizer stages. It generates `tick16` once every three clocks, so the receiver runs on a real enable rather than on every cycle, and one bit lasts 48 clocks. A depth of 16 lets the FIFO be filled completely and then overrun by a seventeenth character within a short run. The slow enable also makes room for a start glitch shorter than the 8-tick confirmation window.

// File: rtl/srx_pkg.sv
// Shared types for the serial receiver: one stored entry holds a byte and its three error tags.
package srx_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } srx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } srx_state_t;

endpackage

// File: rtl/srx_sync.sv
// Line synchronizer: brings the asynchronous serial input into the clock domain.
// Assumes the line idles high; every stage resets to 1 so no false start follows reset.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
// Character deframer: finds a start edge, confirms it at tick 8, then samples each bit
// every 16 ticks. It emits a one-cycle pulse carrying the aligned byte and its error tags.
// Assumes the format inputs stay stable while a frame is in flight.
module srx_deframer
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx,
    input  logic [1:0] data_bits,
    input  logic       parity_en,
    input  logic       parity_even,
    output logic       char_valid,
    output srx_entry_t char_out
);
    srx_state_t state;
    logic [3:0] cnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       pbit;
    logic       armed;
    logic       all_low;

    logic [7:0] aligned;
    logic       par_bad;
    logic       is_brk;

    // Right-align the shifted-in bits and form the tags for the character being closed.
    always_comb begin
        aligned = shreg >> (3'd3 - {1'b0, data_bits});
        par_bad = parity_en & ((^aligned) ^ pbit ^ ~parity_even);
        is_brk  = all_low & ~rx;
    end

    // Frame state machine, advanced only on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            armed      <= 1'b0;
            all_low    <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick16) begin
                case (state)
                    RX_IDLE: begin
                        if (armed && !rx) begin
                            state <= RX_START;
                            cnt   <= '0;
                            armed <= 1'b0;
                        end else begin
                            armed <= rx;
                        end
                    end
                    RX_START: begin
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                            if (!rx) begin
                                state   <= RX_DATA;
                                bitn    <= '0;
                                all_low <= 1'b1;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == 4'd15) begin
                            cnt     <= '0;
                            shreg   <= {rx, shreg[7:1]};
                            all_low <= all_low & ~rx;
                            bitn    <= bitn + 3'd1;
                            if (bitn == 3'd4 + {1'b0, data_bits})
                                state <= parity_en ? RX_PAR : RX_STOP;
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == 4'd15) begin
                            cnt     <= '0;
                            pbit    <= rx;
                            all_low <= all_low & ~rx;
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == 4'd15) begin
                            cnt            <= '0;
                            char_valid     <= 1'b1;
                            char_out.data  <= is_brk ? 8'h00 : aligned;
                            char_out.perr  <= is_brk ? 1'b0 : par_bad;
                            char_out.ferr  <= ~rx;
                            char_out.brk   <= is_brk;
                            state          <= RX_IDLE;
                            armed          <= 1'b0;
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R2: a start edge found high at tick 8 is dropped.
    assert_glitch_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && tick16 && cnt == 4'd7 && rx) |=> (state == RX_IDLE && !char_valid));

    // R6: a break entry carries zero data and a framing error.
    assert_break_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_out.brk) |-> (char_out.data == 8'h00 && char_out.ferr));

    // R3: each character completion is a single-cycle pulse.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);
endmodule

// File: rtl/srx_store.sv
// Entry store: a ring of DEPTH tagged entries whose usable capacity is 1 in character mode
// and DEPTH in FIFO mode. It keeps the sticky overrun flag and empties on any mode change.
module srx_store
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_mode,
    input  logic       push,
    input  srx_entry_t push_entry,
    input  logic       rd_en,
    input  logic       status_rd,
    output logic       data_ready,
    output srx_entry_t head,
    output logic       overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    srx_entry_t      mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;
    logic            mode_q;
    logic [CW-1:0]   cap;
    logic            full;
    logic            do_push;
    logic            do_pop;
    logic            mode_chg;

    // Derive capacity, fullness and the accepted operations of this cycle.
    always_comb begin
        cap      = fifo_mode ? CW'(DEPTH) : CW'(1);
        full     = (count >= cap);
        mode_chg = (fifo_mode != mode_q);
        do_push  = push && !full && !mode_chg;
        do_pop   = rd_en && (count != '0) && !mode_chg;
    end

    // Write accepted entries into the ring.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    // Pointer, occupancy and mode tracking; a mode change flushes everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_mode;
            if (mode_chg) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_push)
                    wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
                if (do_pop)
                    rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
                if (do_push && !do_pop)      count <= count + CW'(1);
                else if (do_pop && !do_push) count <= count - CW'(1);
            end
        end
    end

    // Sticky overrun: set by a refused character, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overrun <= 1'b0;
        else if (push && full)      overrun <= 1'b1;
        else if (status_rd)         overrun <= 1'b0;
    end

    // Present the head entry, zeroed when nothing is stored.
    always_comb begin
        data_ready = (count != '0);
        head       = data_ready ? mem[rd_ptr] : '0;
    end

    // R8: occupancy never exceeds the capacity of the mode that filled it.
    assert_count_in_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CW'(DEPTH)) && (!mode_q -> count <= CW'(1)));

    // R9: overrun holds until a status read.
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !status_rd) |=> overrun);

    // R11: a read while empty leaves the store empty unless a character arrives.
    assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && rd_en && !push) |=> !data_ready);

    // R10: a mode change leaves the store empty on the next cycle.
    assert_flush_on_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode != mode_q) |=> !data_ready);
endmodule

// File: rtl/srx_tagged.sv
// Top of the serial receiver: synchronizer, deframer and tagged entry store.
// Assumes tick16 is a one-cycle enable at 16x the bit rate from an external divisor.
module srx_tagged
    import srx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_line,
    input  logic [1:0] data_bits,
    input  logic       parity_en,
    input  logic       parity_even,
    input  logic       fifo_mode,
    input  logic       rd_en,
    input  logic       status_rd,
    output logic       data_ready,
    output logic [7:0] head_data,
    output logic       head_perr,
    output logic       head_ferr,
    output logic       head_brk,
    output logic       overrun
);
    logic       rx_s;
    logic       char_valid;
    srx_entry_t char_ent;
    srx_entry_t head;

    srx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    srx_deframer i_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .rx         (rx_s),
        .data_bits  (data_bits),
        .parity_en  (parity_en),
        .parity_even(parity_even),
        .char_valid (char_valid),
        .char_out   (char_ent)
    );

    srx_store #(.DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .push      (char_valid),
        .push_entry(char_ent),
        .rd_en     (rd_en),
        .status_rd (status_rd),
        .data_ready(data_ready),
        .head      (head),
        .overrun   (overrun)
    );

    // Unpack the head entry onto the output pins.
    always_comb begin
        head_data = head.data;
        head_perr = head.perr;
        head_ferr = head.ferr;
        head_brk  = head.brk;
    end

    // R1: the cycle after reset shows nothing stored and no overrun.
    assert_reset_clean_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!data_ready && !overrun));
endmodule

// File: tb/test_srx_tagged.sv
module test_srx_tagged;
    localparam int DIV = 3;
    localparam int BIT = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] data_bits = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_even = 1'b1;
    logic       fifo_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic       status_rd = 1'b0;
    logic       data_ready;
    logic [7:0] head_data;
    logic       head_perr, head_ferr, head_brk, overrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    srx_tagged #(.DEPTH(16), .SYNC_STAGES(2)) i_srx_tagged (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .data_bits(data_bits), .parity_en(parity_en), .parity_even(parity_even),
        .fifo_mode(fifo_mode), .rd_en(rd_en), .status_rd(status_rd),
        .data_ready(data_ready), .head_data(head_data), .head_perr(head_perr),
        .head_ferr(head_ferr), .head_brk(head_brk), .overrun(overrun)
    );

    always #4 clk = ~clk;

    // Oversampling enable: one cycle in DIV, driven away from the rising edge.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick16 = (c == 0);
            c = (c == DIV - 1) ? 0 : c + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit pen,
                        input bit pbit, input bit stop_v);
        rx_line = 1'b0; wait_clk(BIT);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i]; wait_clk(BIT);
        end
        if (pen) begin rx_line = pbit; wait_clk(BIT); end
        rx_line = stop_v; wait_clk(BIT);
        rx_line = 1'b1; wait_clk(2 * BIT);
    endtask

    task automatic pop;
        rd_en = 1'b1; wait_clk(1); rd_en = 1'b0; wait_clk(1);
    endtask

    task automatic expect_head(input string req, input logic [7:0] d,
                               input bit pe, input bit fe, input bit bk);
        chk(req, "data_ready", int'(data_ready), 1);
        chk(req, "head_data", int'(head_data), int'(d));
        chk(req, "head_perr", int'(head_perr), int'(pe));
        chk(req, "head_ferr", int'(head_ferr), int'(fe));
        chk(req, "head_brk", int'(head_brk), int'(bk));
    endtask

    task automatic t_reset;
        chk("R1", "data_ready", int'(data_ready), 0);
        chk("R1", "overrun", int'(overrun), 0);
    endtask

    task automatic t_basic;
        send(8'hA5, 8, 0, 0, 1);
        expect_head("R3", 8'hA5, 0, 0, 0);
        pop;
        chk("R3", "empty after pop", int'(data_ready), 0);
        pop;
        chk("R11", "empty read", int'(data_ready), 0);
        send(8'h3E, 8, 0, 0, 1);
        expect_head("R11", 8'h3E, 0, 0, 0);
        pop;
    endtask

    task automatic t_widths;
        for (int s = 0; s < 4; s++) begin
            logic [7:0] m;
            data_bits = 2'(s);
            m = 8'hD6 & ((8'h1 << (5 + s)) - 8'h1);
            send(8'hD6, 5 + s, 0, 0, 1);
            expect_head("R3", m, 0, 0, 0);
            pop;
        end
        data_bits = 2'd3;
    endtask

    task automatic t_parity;
        parity_en = 1'b1;
        parity_even = 1'b1;
        send(8'h37, 8, 1, ^8'h37, 1);
        expect_head("R4", 8'h37, 0, 0, 0); pop;
        send(8'h37, 8, 1, ~^8'h37, 1);
        expect_head("R4", 8'h37, 1, 0, 0); pop;
        parity_even = 1'b0;
        data_bits = 2'd0;
        send(8'h15, 5, 1, ~^5'h15, 1);
        expect_head("R4", 8'h15, 0, 0, 0); pop;
        send(8'h15, 5, 1, ^5'h15, 1);
        expect_head("R4", 8'h15, 1, 0, 0); pop;
        data_bits = 2'd3;
        parity_en = 1'b0;
        parity_even = 1'b1;
    endtask

    task automatic t_framing;
        send(8'h3C, 8, 0, 0, 0);
        expect_head("R5", 8'h3C, 0, 1, 0); pop;
    endtask

    task automatic t_glitch;
        rx_line = 1'b0; wait_clk(5 * DIV);
        rx_line = 1'b1; wait_clk(12 * BIT);
        chk("R2", "glitch stored nothing", int'(data_ready), 0);
        send(8'h5A, 8, 0, 0, 1);
        expect_head("R2", 8'h5A, 0, 0, 0); pop;
    endtask

    task automatic t_break;
        rx_line = 1'b0; wait_clk(12 * BIT);
        expect_head("R6", 8'h00, 0, 1, 1);
        pop;
        wait_clk(10 * BIT);
        chk("R6", "no restart while low", int'(data_ready), 0);
        rx_line = 1'b1; wait_clk(2 * BIT);
        chk("R6", "no entry on release", int'(data_ready), 0);
        send(8'h81, 8, 0, 0, 1);
        expect_head("R6", 8'h81, 0, 0, 0); pop;
    endtask

    task automatic t_char_overrun;
        send(8'h11, 8, 0, 0, 1);
        send(8'h22, 8, 0, 0, 1);
        chk("R7", "overrun", int'(overrun), 1);
        expect_head("R7", 8'h11, 0, 0, 0);
        pop;
        chk("R7", "only one held", int'(data_ready), 0);
        chk("R9", "overrun sticky", int'(overrun), 1);
        status_rd = 1'b1; wait_clk(1); status_rd = 1'b0; wait_clk(1);
        chk("R9", "overrun cleared", int'(overrun), 0);
    endtask

    task automatic t_fifo_order;
        fifo_mode = 1'b1; wait_clk(2);
        parity_en = 1'b1;
        parity_even = 1'b1;
        send(8'h01, 8, 1, ^8'h01, 1);
        send(8'h02, 8, 1, ^8'h02, 0);
        send(8'h03, 8, 1, ~^8'h03, 1);
        expect_head("R8", 8'h01, 0, 0, 0); pop;
        expect_head("R8", 8'h02, 0, 1, 0); pop;
        expect_head("R8", 8'h03, 1, 0, 0); pop;
        chk("R8", "drained", int'(data_ready), 0);
        parity_en = 1'b0;
    endtask

    task automatic t_fifo_full;
        for (int i = 0; i < 17; i++) send(8'(8'h40 + i), 8, 0, 0, 1);
        chk("R9", "overrun on full", int'(overrun), 1);
        for (int i = 0; i < 16; i++) begin
            chk("R9", "kept entry", int'(head_data), 8'h40 + i);
            pop;
        end
        chk("R9", "seventeenth dropped", int'(data_ready), 0);
        status_rd = 1'b1; wait_clk(1); status_rd = 1'b0; wait_clk(1);
        chk("R9", "overrun cleared", int'(overrun), 0);
    endtask

    task automatic t_flush;
        send(8'h66, 8, 0, 0, 1);
        send(8'h77, 8, 0, 0, 1);
        chk("R10", "filled", int'(data_ready), 1);
        fifo_mode = 1'b0; wait_clk(2);
        chk("R10", "flushed", int'(data_ready), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset;
        wait_clk(2 * BIT);
        t_basic;
        t_widths;
        t_parity;
        t_framing;
        t_glitch;
        t_break;
        t_char_overrun;
        t_fifo_order;
        t_fifo_full;
        t_flush;
        finish_run;
    end

    initial begin
        wait_clk(190000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule